// File: doc/BRIEF.md
# Serial Split-Word PWM Setting Loader

This block takes PWM duty settings for four channels from a synchronous serial link and delivers them to the PWM engines. A controller frames each transfer with an active-low chip-select, clocks bits in on a shift clock and marks each finished byte with a write strobe. A 12-bit setting takes two bytes in one frame. The first byte carries the four least significant setting bits and a channel number. The second byte carries the eight most significant bits.

A setting is complete only when its second byte arrives. It then waits in a per-channel staging register. The engines signal a shared period boundary with `cycle_end`, and staged settings reach the outputs only at that boundary, so a waveform never changes mid-period. The active-low `clr_n` input clears every channel at the next boundary and switches off every channel's drive enable. A channel drives again only after it has been rewritten and that new setting has been applied.

All inputs are sampled on `clk`. The serial clock and the strobe must each stay high and stay low for at least one `clk` period.

Top module: `pwm_word_loader`

## Requirements
- R1: After `rst_n` is low, `out_duty` is all zero and `out_en` is 4'b0000.
- R2: While `ser_cs_n` is low, each rising edge of `ser_clk` shifts `ser_din` into an 8-bit shift register with the most significant bit first. A rising edge of `ser_wr` takes the eight bits as one byte.
- R3: The first byte of a frame is the low byte. Its bits [3:0] are setting bits 3..0, bits [5:4] are the channel number 0..3, and bits [7:6] must be 00. The second byte of the frame holds setting bits 11..4, and its arrival commits the 12-bit value to that channel's staging register.
- R4: A low byte whose bits [7:6] are not 00 is discarded, and the high byte that follows it in the frame commits nothing. A third or later byte in a frame is ignored.
- R5: A frame that carries only a low byte commits nothing. The low byte of the next frame replaces the pending one.
- R6: A committed value appears on its channel's `out_duty` slice (channel n at bits [12n+11:12n]) in the `clk` cycle after a `cycle_end` pulse, and that channel's `out_en` bit goes to 1 at the same time. Between boundaries, `out_duty` and `out_en` do not change.
- R7: When `cycle_end` is high while `clr_n` is low, the next cycle shows every `out_duty` slice at zero and `out_en` at 0000, and all staged values are dropped. Bytes written while `clr_n` is low are ignored.
- R8: After a clear, a channel keeps its `out_en` bit at 0 across later boundaries until a new value has been committed to it and applied. A channel whose enable is 0 shows a zero setting.
- R9: When a channel is committed twice before a boundary, the later value is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial shift clock, sampled on `clk` |
| ser_din | input | 1 | Serial data bit |
| ser_wr | input | 1 | Byte write strobe, rising edge active |
| clr_n | input | 1 | Active-low clear request, acted on at a boundary |
| cycle_end | input | 1 | One-cycle pulse at each PWM period boundary |
| out_duty | output | 48 | Applied settings, 12 bits per channel |
| out_en | output | 4 | Per-channel drive enable (0 = output held off) |

## Verification
The hardest situation to reach is a sequence spread over several frames and boundaries. One example is a clear, then a boundary with no write, then a rewrite of only one channel. Another is a low-byte-only frame followed by a frame aimed at a different channel. The bench reaches these with directed scenarios and then with a random mix of valid pairs, corrupt low bytes, short frames, long frames, boundaries and clear pulses. A reference model in the bench tracks the pending, staged and applied state for every step.

// File: rtl/pwm_word_loader.sv
module pwm_word_loader #(
  parameter int NCH = 4,
  parameter int DW  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_cs_n,
  input  logic            ser_clk,
  input  logic            ser_din,
  input  logic            ser_wr,
  input  logic            clr_n,
  input  logic            cycle_end,
  output logic [NCH*DW-1:0] out_duty,
  output logic [NCH-1:0]  out_en
);
  localparam int BW  = 8;
  localparam int LOW = DW - BW;
  localparam int CW  = $clog2(NCH);

  logic          sclk_q, wr_q;
  logic [BW-1:0] shreg;
  logic [1:0]    idx;
  logic          pend_v;
  logic [LOW-1:0] pend_lo;
  logic [CW-1:0] pend_ch;
  logic [DW-1:0] stage [NCH];
  logic [DW-1:0] act   [NCH];
  logic [NCH-1:0] stg_v;

  wire sclk_rise = ser_clk & ~sclk_q & ~ser_cs_n;
  wire wr_edge   = ser_wr & ~wr_q & ~ser_cs_n;
  wire wr_rise   = wr_edge & clr_n;
  wire lo_ok     = wr_rise && idx == 2'd0 && shreg[7:6] == 2'b00;
  wire hi_ok     = wr_rise && idx == 2'd1 && pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      wr_q    <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      pend_v  <= 1'b0;
      pend_lo <= '0;
      pend_ch <= '0;
      stg_v   <= '0;
      out_en  <= '0;
      for (int i = 0; i < NCH; i++) begin
        stage[i] <= '0;
        act[i]   <= '0;
      end
    end else begin
      sclk_q <= ser_clk;
      wr_q   <= ser_wr;
      if (sclk_rise) shreg <= {shreg[BW-2:0], ser_din};
      if (ser_cs_n) idx <= '0;
      else if (wr_edge && idx != 2'd2) idx <= idx + 2'd1;

      if (wr_rise && idx == 2'd0) begin
        pend_v  <= lo_ok;
        pend_lo <= shreg[LOW-1:0];
        pend_ch <= shreg[LOW+CW-1:LOW];
      end else if (hi_ok || (cycle_end && !clr_n)) begin
        pend_v <= 1'b0;
      end

      if (cycle_end) begin
        for (int i = 0; i < NCH; i++) begin
          if (!clr_n) begin
            act[i]    <= '0;
            out_en[i] <= 1'b0;
            stg_v[i]  <= 1'b0;
          end else if (stg_v[i]) begin
            act[i]    <= stage[i];
            out_en[i] <= 1'b1;
            stg_v[i]  <= 1'b0;
          end
        end
      end
      if (hi_ok) begin
        stage[pend_ch] <= {shreg, pend_lo};
        stg_v[pend_ch] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign out_duty[g*DW +: DW] = act[g];
    AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en[g] |-> act[g] == '0); // R8
  end

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shreg[0] == $past(ser_din)); // R2
  AST_COMMIT_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ok |=> stg_v != '0); // R3
  AST_BAD_LOW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && idx == 2'd0 && shreg[7:6] != 2'b00) |=> !pend_v); // R4
  AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end |=> $stable(out_duty) && $stable(out_en)); // R6
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && !clr_n) |=> out_en == '0 && out_duty == '0); // R7
endmodule

// File: tb/pwm_word_loader_test.sv
module pwm_word_loader_test;
  logic clk = 0, rst_n = 0, ser_cs_n = 1, ser_clk = 0, ser_din = 0, ser_wr = 0;
  logic clr_n = 1, cycle_end = 0;
  logic [47:0] out_duty;
  logic [3:0]  out_en;
  int checks = 0, errors = 0;

  logic [11:0] m_stg [4];
  logic [11:0] m_act [4];
  logic [3:0]  m_sv, m_en;
  logic        m_pv;
  logic [3:0]  m_plo;
  logic [1:0]  m_pch;

  always #2.5 clk = ~clk;

  pwm_word_loader uut (.*);

  function automatic logic [47:0] exp_duty();
    return {m_act[3], m_act[2], m_act[1], m_act[0]};
  endfunction

  task automatic check_out(string tag);
    checks++;
    if (out_duty !== exp_duty() || out_en !== m_en) begin
      errors++;
      $display("FAIL %s duty=%h exp=%h en=%b exp=%b", tag, out_duty, exp_duty(), out_en, m_en);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      ser_din = b[i];
      @(negedge clk); ser_clk = 1;
      repeat (2) @(negedge clk); ser_clk = 0;
      @(negedge clk);
    end
    ser_wr = 1; repeat (2) @(negedge clk);
    ser_wr = 0; repeat (2) @(negedge clk);
  endtask

  task automatic frame(int n, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, string tag);
    logic [7:0] bs [3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    ser_cs_n = 0; @(negedge clk);
    for (int k = 0; k < n; k++) begin
      send_byte(bs[k]);
      if (clr_n) begin
        if (k == 0) begin
          m_pv = (bs[k][7:6] == 2'b00); m_plo = bs[k][3:0]; m_pch = bs[k][5:4];
        end else if (k == 1 && m_pv) begin
          m_stg[m_pch] = {bs[k], m_plo}; m_sv[m_pch] = 1; m_pv = 0;
        end
      end
    end
    ser_cs_n = 1; repeat (2) @(negedge clk);
    check_out(tag);
  endtask

  task automatic boundary(string tag);
    cycle_end = 1; @(negedge clk); cycle_end = 0;
    for (int c = 0; c < 4; c++) begin
      if (!clr_n) begin m_act[c] = 0; m_en[c] = 0; m_sv[c] = 0; end
      else if (m_sv[c]) begin m_act[c] = m_stg[c]; m_en[c] = 1; m_sv[c] = 0; end
    end
    if (!clr_n) m_pv = 0;
    check_out(tag);
  endtask

  function automatic logic [7:0] lo(int ch, logic [3:0] d);
    return {2'b00, ch[1:0], d};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_sv = 0; m_en = 0; m_pv = 0; m_plo = 0; m_pch = 0;
    for (int c = 0; c < 4; c++) begin m_stg[c] = 0; m_act[c] = 0; end
    repeat (3) @(negedge clk);
    check_out("R1 reset state");
    rst_n = 1; @(negedge clk);

    frame(2, lo(1, 4'hC), 8'hA5, 0, "R6 mid-cycle hold after R2/R3 write");
    boundary("R3 R6 ch1 applied at boundary");
    frame(2, lo(0, 4'h1), 8'h80, 0, "R9 first write held");
    frame(2, lo(0, 4'hE), 8'h3B, 0, "R9 second write held");
    boundary("R9 later commit wins");
    frame(2, 8'b0100_0011, 8'hFF, 0, "R4 reserved bits set");
    boundary("R4 bad low byte commits nothing");
    frame(3, lo(2, 4'h7), 8'h12, 8'h99, "R4 third byte ignored");
    boundary("R4 ch2 gets pair value only");
    frame(1, lo(2, 4'h3), 0, 0, "R5 low-only frame");
    frame(2, lo(3, 4'h5), 8'hC6, 0, "R5 replaced pending");
    boundary("R5 ch3 written, ch2 unchanged");
    boundary("R6 empty boundary keeps values");

    clr_n = 0;
    frame(2, lo(1, 4'h9), 8'h44, 0, "R7 write ignored during clear");
    boundary("R7 all channels cleared");
    clr_n = 1;
    boundary("R8 outputs stay off after clear");
    frame(2, lo(2, 4'hF), 8'hFF, 0, "R8 rewrite staged");
    boundary("R8 only rewritten channel enabled");
    frame(2, lo(0, 4'h0), 8'h00, 0, "R8 zero value staged");
    boundary("R8 zero value still enables");

    for (int it = 0; it < 300; it++) begin
      int r = $urandom % 10;
      int ch = $urandom % 4;
      logic [3:0] d = 4'($urandom);
      logic [7:0] u = 8'($urandom);
      case (r)
        0: frame(2, {2'($urandom % 3 + 1), ch[1:0], d}, u, 0, "R4 random bad low byte");
        1: frame(1, lo(ch, d), 0, 0, "R5 random low-only frame");
        2: frame(3, lo(ch, d), u, 8'($urandom), "R4 random long frame");
        8: boundary("R6 random boundary");
        9: begin clr_n = 0; boundary("R7 random clear"); clr_n = 1; end
        default: frame(2, lo(ch, d), u, 0, "R3 random pair");
      endcase
      if (it % 3 == 2) boundary("R6 periodic boundary");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule